// File: doc/BRIEF.md
# AXI Narrow Write Strobe Generator

This block turns one AXI write burst command into the strobe for each beat of that burst. The command carries a start address, the beats-minus-one length, the transfer size and the burst type. Only the start address is given, so the block holds the current beat address and moves it one step on each completed beat. It sets only the byte lanes that the beat address and transfer size allow. All other lanes stay low. A narrow transfer therefore gets a partial strobe, and so does a first beat that starts off the size boundary.

Lane selection is byte-invariant, so there is no endian setting. The bus width in bytes is a parameter. One command is held at a time. The command port stays closed from acceptance until the final beat's handshake. Each beat's strobe is held steady on the beat output until the data side takes it.

Top module: `axi_wstrb_gen`

## Requirements
- R1: After reset, cmd_ready is 1 and wb_valid is 0.
- R2: For a legal size (2^cmd_size no wider than the bus), lane i of wb_strb is 1 exactly when L <= i <= U. L is the beat address modulo BUS_BYTES. U is the beat address aligned down to 2^size, taken modulo BUS_BYTES, plus 2^size − 1. On the first beat the beat address is cmd_addr, so an unaligned start gets a partial run of lanes.
- R3: With cmd_burst = 2'b01 (incrementing), each later beat address is the previous one aligned down to 2^size, plus 2^size.
- R4: With cmd_burst = 2'b00 (fixed), every beat uses cmd_addr unchanged, unaligned start included.
- R5: With cmd_burst = 2'b10 (wrapping), the region is (cmd_len+1)·2^size bytes. The next address is the incremented address folded back into the aligned region that holds the current address. cmd_len+1 must be 2, 4, 8 or 16.
- R6: The beat advances only on a clock edge where wb_valid and wb_ready are both 1. While wb_ready is 0, wb_valid, wb_strb, wb_last and wb_err hold their values.
- R7: wb_last is 1 on beat number cmd_len (counting from 0) and 0 on all other beats. After that beat's handshake, wb_valid is 0 on the next cycle.
- R8: If 2^cmd_size is wider than the bus, wb_err is 1 and wb_strb is all zero on every beat of that burst. Otherwise wb_err is 0.
- R9: cmd_ready is 0 while a burst is in progress and 1 when idle. A command is taken on a clock edge where cmd_valid and cmd_ready are both 1.
- R10: The reserved burst code 2'b11 steps addresses the same way as the incrementing burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Number of beats minus one |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| wb_valid | output | 1 | A beat strobe is presented |
| wb_ready | input | 1 | Data side takes the beat |
| wb_strb | output | BUS_BYTES | Byte lane strobe for the current beat |
| wb_last | output | 1 | Current beat is the final one |
| wb_err | output | 1 | Transfer size exceeds bus width |

## Verification
The bench aims at an unaligned first beat under each burst type. A design that took the upper lane from the raw start address instead of the size-aligned one would set lanes past the size boundary there. A fixed burst with an unaligned start would show it as a partial strobe that wrongly moves or widens on later beats. Wrapping bursts are started next to the region end, so a wrong fold mask sends the address past the region instead of back to its base. Random stalls check that no beat is skipped or changed while the data side waits. Oversized transfers and the reserved burst code check that the error flag clears every lane and that the reserved code steps like incrementing.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   typedef enum logic [1:0] {
      BT_FIXED = 2'b00,
      BT_INCR  = 2'b01,
      BT_WRAP  = 2'b10,
      BT_RSVD  = 2'b11
   } burst_e;
endpackage

// File: rtl/wsg_lane_mask.sv
module wsg_lane_mask #(
   parameter int ADDR_W    = 32,
   parameter int BUS_BYTES = 4
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [2:0]           size,
   output logic [BUS_BYTES-1:0] strb,
   output logic                 err
);
   localparam int LANE_W = $clog2(BUS_BYTES);

   logic              size_ok;
   logic [LANE_W-1:0] lower;
   logic [LANE_W:0]   span_m1;
   logic [LANE_W:0]   upper;

   assign size_ok = ({1'b0, size} <= 4'(LANE_W));
   assign err     = !size_ok;
   assign lower   = addr[LANE_W-1:0];

   always_comb begin
      if (size_ok) span_m1 = ((LANE_W+1)'(1) << size) - (LANE_W+1)'(1);
      else         span_m1 = '0;
   end

   // the upper lane is based on the size-aligned address, so a first beat
   // that starts off the size boundary gets only its trailing lanes
   assign upper = ({1'b0, lower} & ~span_m1) + span_m1;

   for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
      localparam logic [LANE_W:0] IDX = (LANE_W+1)'(i);
      assign strb[i] = size_ok && (IDX >= {1'b0, lower}) && (IDX <= upper);
   end
endmodule

// File: rtl/wsg_addr_step.sv
module wsg_addr_step
   import wsg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic [LEN_W-1:0]  len,
   input  burst_e            burst,
   output logic [ADDR_W-1:0] next_addr
);
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] incr;
   logic [ADDR_W-1:0] wrap_len;
   logic [ADDR_W-1:0] wrap_mask;
   logic [ADDR_W-1:0] wrapped;

   assign step      = ADDR_W'(1) << size;
   assign aligned   = addr & ~(step - ADDR_W'(1));
   assign incr      = aligned + step;
   assign wrap_len  = (ADDR_W'(len) + ADDR_W'(1)) << size;
   assign wrap_mask = wrap_len - ADDR_W'(1);
   assign wrapped   = (addr & ~wrap_mask) | (incr & wrap_mask);

   always_comb begin
      unique case (burst)
         BT_FIXED: next_addr = addr;
         BT_WRAP:  next_addr = wrapped;
         default:  next_addr = incr;
      endcase
   end
endmodule

// File: rtl/wsg_beat_ctrl.sv
module wsg_beat_ctrl #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             advance,
   input  logic [LEN_W-1:0] len,
   output logic             busy,
   output logic             last
);
   logic [LEN_W-1:0] beat_q;

   assign last = busy && (beat_q == len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         beat_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         beat_q <= '0;
      end else if (advance) begin
         if (last) busy <= 1'b0;
         beat_q <= beat_q + LEN_W'(1);
      end
   end
endmodule

// File: rtl/axi_wstrb_gen.sv
module axi_wstrb_gen
   import wsg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BUS_BYTES = 4,
   parameter int LEN_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic [2:0]           cmd_size,
   input  logic [1:0]           cmd_burst,
   output logic                 wb_valid,
   input  logic                 wb_ready,
   output logic [BUS_BYTES-1:0] wb_strb,
   output logic                 wb_last,
   output logic                 wb_err
);
   localparam int LANE_W = $clog2(BUS_BYTES);

   if (BUS_BYTES < 2 || BUS_BYTES > 128 || (1 << LANE_W) != BUS_BYTES) begin : g_bad_bus
      $error("BUS_BYTES must be a power of two from 2 to 128");
   end
   if (ADDR_W < LEN_W + 8) begin : g_bad_addr
      $error("ADDR_W too narrow for the largest wrap region");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("LEN_W must be 1 to 8");
   end

   logic              busy;
   logic              cmd_fire;
   logic              beat_fire;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic [2:0]        size_q;
   logic [LEN_W-1:0]  len_q;
   burst_e            burst_q;

   assign cmd_ready = !busy;
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign wb_valid  = busy;
   assign beat_fire = wb_valid && wb_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         size_q  <= '0;
         len_q   <= '0;
         burst_q <= BT_FIXED;
      end else if (cmd_fire) begin
         addr_q  <= cmd_addr;
         size_q  <= cmd_size;
         len_q   <= cmd_len;
         burst_q <= burst_e'(cmd_burst);
      end else if (beat_fire) begin
         addr_q  <= addr_nxt;
      end
   end

   wsg_beat_ctrl #(.LEN_W(LEN_W)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cmd_fire),
      .advance (beat_fire),
      .len     (len_q),
      .busy    (busy),
      .last    (wb_last)
   );

   wsg_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_step (
      .addr      (addr_q),
      .size      (size_q),
      .len       (len_q),
      .burst     (burst_q),
      .next_addr (addr_nxt)
   );

   wsg_lane_mask #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) i_mask (
      .addr (addr_q),
      .size (size_q),
      .strb (wb_strb),
      .err  (wb_err)
   );
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
   parameter int BUS_BYTES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_ready,
   input logic                 wb_valid,
   input logic                 wb_ready,
   input logic [BUS_BYTES-1:0] wb_strb,
   input logic                 wb_last,
   input logic                 wb_err
);
   logic [BUS_BYTES:0] ext;
   logic [BUS_BYTES:0] low_bit;
   logic [BUS_BYTES:0] run_sum;
   logic               contiguous;

   always_comb begin
      ext        = {1'b0, wb_strb};
      low_bit    = ext & (~ext + (BUS_BYTES+1)'(1));
      run_sum    = ext + low_bit;
      contiguous = ((run_sum & ext) == '0);
   end

   AST_BUSY_CLOSES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !cmd_ready); // R9
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_strb) && $stable(wb_last) && $stable(wb_err))); // R6
   AST_ERR_CLEARS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_err) |-> (wb_strb == '0)); // R8
   AST_LANES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_err) |-> (wb_strb != '0 && contiguous)); // R2
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_ready && wb_last) |=> !wb_valid); // R7
   AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_valid |-> (cmd_ready && !wb_last)); // R9
endmodule

bind axi_wstrb_gen wsg_checker #(.BUS_BYTES(BUS_BYTES)) i_wsg_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .wb_valid  (wb_valid),
   .wb_ready  (wb_ready),
   .wb_strb   (wb_strb),
   .wb_last   (wb_last),
   .wb_err    (wb_err)
);

// File: tb/test_axi_wstrb_gen.sv
`timescale 1ns/1ps
module test_axi_wstrb_gen;
   localparam int AW    = 32;
   localparam int BB    = 4;
   localparam int LENW  = 8;
   localparam int LANES = $clog2(BB);

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cmd_valid;
   logic            cmd_ready;
   logic [AW-1:0]   cmd_addr;
   logic [LENW-1:0] cmd_len;
   logic [2:0]      cmd_size;
   logic [1:0]      cmd_burst;
   logic            wb_valid;
   logic            wb_ready;
   logic [BB-1:0]   wb_strb;
   logic            wb_last;
   logic            wb_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   axi_wstrb_gen #(.ADDR_W(AW), .BUS_BYTES(BB), .LEN_W(LENW)) i_axi_wstrb_gen (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_strb(wb_strb),
      .wb_last(wb_last), .wb_err(wb_err)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [BB-1:0] exp_strb(input logic [AW-1:0] a, input int sz);
      logic [BB-1:0] s = '0;
      int nb, lo, up;
      if (sz > LANES) return '0;
      nb = 1 << sz;
      lo = int'(a % BB);
      up = int'((a & ~AW'(nb - 1)) % BB) + nb - 1;
      for (int i = 0; i < BB; i++) s[i] = (i >= lo) && (i <= up);
      return s;
   endfunction

   function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] a, input int sz, input int len, input int bt);
      logic [AW-1:0] nb, inc, m;
      if (bt == 0) return a;
      nb  = AW'(1) << sz;
      inc = (a & ~(nb - 1)) + nb;
      if (bt == 2) begin
         m = (AW'(len + 1) << sz) - 1;
         return (a & ~m) | (inc & m);
      end
      return inc;
   endfunction

   task automatic run_burst(input logic [AW-1:0] a0, input int len, input int sz, input int bt, input int max_stall);
      logic [AW-1:0] a;
      logic [BB-1:0] es;
      string tag;
      int st;
      @(negedge clk);
      chk("R9", "cmd_ready when idle", cmd_ready, 1);
      cmd_valid = 1'b1; cmd_addr = a0; cmd_len = LENW'(len);
      cmd_size = 3'(sz); cmd_burst = 2'(bt);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9", "cmd_ready while busy", cmd_ready, 0);
      a = a0;
      for (int b = 0; b <= len; b++) begin
         es = exp_strb(a, sz);
         if (sz > LANES)  tag = "R8";
         else if (b == 0) tag = "R2";
         else if (bt == 0) tag = "R4";
         else if (bt == 2) tag = "R5";
         else if (bt == 3) tag = "R10";
         else tag = "R3";
         chk("R6", "wb_valid", wb_valid, 1);
         chk(tag, "wb_strb", wb_strb, es);
         chk("R7", "wb_last", wb_last, (b == len));
         chk("R8", "wb_err", wb_err, (sz > LANES));
         st = (max_stall > 0) ? $urandom_range(max_stall, 0) : 0;
         for (int k = 0; k < st; k++) begin
            @(negedge clk);
            chk("R6", "strb held in stall", wb_strb, es);
            chk("R6", "last held in stall", wb_last, (b == len));
         end
         wb_ready = 1'b1;
         @(negedge clk);
         wb_ready = 1'b0;
         a = exp_next(a, sz, len, bt);
      end
      chk("R7", "wb_valid after last", wb_valid, 0);
      chk("R9", "cmd_ready after last", cmd_ready, 1);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0;
      cmd_size = '0; cmd_burst = '0; wb_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "cmd_ready in reset", cmd_ready, 1);
      chk("R1", "wb_valid in reset", wb_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cmd_ready after reset", cmd_ready, 1);
      chk("R1", "wb_valid after reset", wb_valid, 0);
      // ready high while idle must not create a beat
      wb_ready = 1'b1;
      @(negedge clk);
      chk("R6", "no beat from idle ready", wb_valid, 0);
      wb_ready = 1'b0;

      run_burst(32'h33, 3, 1, 1, 0);   // unaligned half-word incr
      run_burst(32'h05, 3, 2, 0, 2);   // unaligned word fixed
      run_burst(32'h07, 5, 0, 1, 1);   // byte incr crossing a bus word
      run_burst(32'h30, 15, 1, 2, 1);  // half-word wrap of 32 bytes
      run_burst(32'h3C, 3, 2, 2, 0);   // word wrap starting at region end
      run_burst(32'h11, 2, 3, 1, 1);   // oversized transfer
      run_burst(32'h0A, 3, 1, 3, 1);   // reserved burst code
      run_burst(32'h40, 0, 2, 1, 3);   // single beat

      for (int n = 0; n < 40; n++) begin
         int bt  = $urandom_range(3, 0);
         int sz  = ($urandom_range(9, 0) == 0) ? 3 : $urandom_range(2, 0);
         int len;
         logic [AW-1:0] a0 = AW'($urandom_range(16'hFFFF, 0));
         if (bt == 2) begin
            len = (2 << $urandom_range(3, 0)) - 1;
            a0  = a0 & ~((AW'(1) << sz) - 1);
         end else begin
            len = $urandom_range(15, 0);
         end
         run_burst(a0, len, sz, bt, 2);
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule